// File: doc/BRIEF.md
# Lockable Watchdog Timer with Kick Key

This block is a watchdog timer sitting on an APB bus. Software first programs a 32-bit reload count, then sets the enable bit in the control register. From that moment the watchdog can no longer be switched off, and its reload count is frozen. The counter then steps down by one on every clock. To keep the system alive, software must periodically write a fixed 16-bit key into the low half of the control register, which puts the counter back to the reload count.

If the counter is allowed to sit at zero, the block raises a one-cycle reset request toward the chip's reset logic. It also stores a watchdog cause code in a small cause register, then reloads the counter and keeps running. The cause register comes out of reset holding the pin-reset code and software may overwrite it. The reset circuitry itself lives outside this block.

Top module: `wdt_ctrl`

## Requirements
- R1: After reset the reload register (offset 0x0) reads 0x0000_8000, the control register (offset 0x4) reads 0 (disabled, count 0), the cause register (offset 0x8, bits 1:0) reads 2'b01 and `wdt_rst_req` is low; while disabled the counter stays at 0.
- R2: While disabled, a write to offset 0x0 sets the reload register to the written 32-bit value, and a read returns it.
- R3: A control write with bit 31 set, while disabled, enables the watchdog and loads the counter from the reload register in the same clock edge; the control register reads bit 31 = enable and bits 15:0 = low 16 bits of the counter, other bits 0.
- R4: Once enabled, no control write clears the enable; only reset does.
- R5: While enabled, writes to the reload register are ignored.
- R6: While enabled, the counter drops by exactly one per clock unless reloaded.
- R7: A control write whose bits 15:0 equal 0x6699, while enabled, reloads the counter; any other control write leaves it running undisturbed, and the key has no effect while disabled.
- R8: When the counter is 0 at a clock edge with no kick, `wdt_rst_req` is high for exactly the following cycle, the cause register becomes 2'b11, and the counter reloads and keeps counting, so expiries repeat every reload+1 cycles.
- R9: The cause register is read/write in bits 1:0; an expiry in the same edge as a software write wins.
- R10: `pready` is always high and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| wdt_rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The counter is read back through the control register after enabling, after a disable attempt, after a non-key write and after a kick. The expected value is derived from the bench's own cycle count since the loading write, so a stalled, doubled or spuriously reloaded counter all give distinct mismatches. A key write before enable and a reload write after enable tell the lock logic apart from plain register storage. Free-running expiry is timed over two periods, which separates an off-by-one in the zero detection from a missing reload.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W = 32;

  // register byte offsets
  localparam int unsigned OFS_RELOAD = 32'h0;
  localparam int unsigned OFS_CTRL   = 32'h4;
  localparam int unsigned OFS_CAUSE  = 32'h8;

  localparam int unsigned EN_BIT = 31;

  localparam logic [1:0] CAUSE_PIN = 2'b01;
  localparam logic [1:0] CAUSE_WDT = 2'b11;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_RELOAD,
    SEL_CTRL,
    SEL_CAUSE
  } wdt_sel_e;

  typedef struct packed {
    logic              wr;
    wdt_sel_e          sel;
    logic [DATA_W-1:0] wdata;
  } wdt_req_t;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_apb_if.sv
module wdt_apb_if
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned VIEW_W = 16
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [CNT_W-1:0]  reload_q,
  input  logic              en_q,
  input  logic [VIEW_W-1:0] cnt_view,
  input  logic [1:0]        cause_q,
  output wdt_req_t          req,
  output logic [DATA_W-1:0] prdata
);
  wdt_sel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if (paddr == ADDR_W'(OFS_RELOAD))     sel = SEL_RELOAD;
    else if (paddr == ADDR_W'(OFS_CTRL))  sel = SEL_CTRL;
    else if (paddr == ADDR_W'(OFS_CAUSE)) sel = SEL_CAUSE;
  end

  always_comb begin
    req.wr    = psel & penable & pwrite;
    req.sel   = sel;
    req.wdata = pwdata;
  end

  always_comb begin
    prdata = '0;
    unique case (sel)
      SEL_RELOAD: prdata = DATA_W'(reload_q);
      SEL_CTRL: begin
        prdata[VIEW_W-1:0] = cnt_view;
        prdata[EN_BIT]     = en_q;
      end
      SEL_CAUSE:  prdata[1:0] = cause_q;
      default:    prdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned      CNT_W       = 32,
  parameter int unsigned      KEY_W       = 16,
  parameter logic [KEY_W-1:0] KEY         = 16'h6699,
  parameter logic [CNT_W-1:0] RELOAD_INIT = 32'h0000_8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wdt_req_t         req,
  input  logic             expire,
  output logic [CNT_W-1:0] reload_q,
  output logic             en_q,
  output logic [1:0]       cause_q,
  output logic             enable_set,
  output logic             kick
);
  logic             wr_reload, wr_ctrl, wr_cause;
  logic [CNT_W-1:0] reload_d;
  logic             reload_ce;
  logic             en_d;
  logic [1:0]       cause_d;
  logic             cause_ce;

  always_comb begin
    wr_reload  = req.wr && (req.sel == SEL_RELOAD);
    wr_ctrl    = req.wr && (req.sel == SEL_CTRL);
    wr_cause   = req.wr && (req.sel == SEL_CAUSE);
    enable_set = wr_ctrl && req.wdata[EN_BIT] && !en_q;
    kick       = wr_ctrl && en_q && (req.wdata[KEY_W-1:0] == KEY);
  end

  // reload: frozen once enabled
  always_comb begin
    reload_ce = wr_reload && !en_q;
    reload_d  = req.wdata[CNT_W-1:0];
  end

  // enable: set-only
  always_comb begin
    en_d = en_q | enable_set;
  end

  // cause: expiry has priority over software
  always_comb begin
    cause_ce = expire | wr_cause;
    cause_d  = expire ? CAUSE_WDT : req.wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= RELOAD_INIT;
    else if (reload_ce) reload_q <= reload_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= CAUSE_PIN;
    else if (cause_ce) cause_q <= cause_d;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire,
  output logic             rst_req_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;
  logic             at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    expire  = en && !load && at_zero;
    cnt_ce  = load || en;
    if (load || expire) cnt_d = reload;
    else                cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= expire;
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned      ADDR_W      = 12,
  parameter int unsigned      CNT_W       = 32,
  parameter int unsigned      KEY_W       = 16,
  parameter logic [KEY_W-1:0] KEY         = 16'h6699,
  parameter logic [CNT_W-1:0] RELOAD_INIT = 32'h0000_8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              wdt_rst_req
);
  localparam int unsigned VIEW_W = (CNT_W < 16) ? CNT_W : 16;

  logic             rst_sync_n;
  wdt_req_t         req;
  logic [CNT_W-1:0] reload;
  logic             enabled;
  logic [1:0]       cause;
  logic             enable_set;
  logic             kick;
  logic [CNT_W-1:0] cnt;
  logic             expire;

  wdt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdt_apb_if #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .VIEW_W(VIEW_W)) u_if (
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .reload_q (reload),
    .en_q     (enabled),
    .cnt_view (cnt[VIEW_W-1:0]),
    .cause_q  (cause),
    .req      (req),
    .prdata   (prdata)
  );

  wdt_regs #(
    .CNT_W(CNT_W), .KEY_W(KEY_W), .KEY(KEY), .RELOAD_INIT(RELOAD_INIT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req        (req),
    .expire     (expire),
    .reload_q   (reload),
    .en_q       (enabled),
    .cause_q    (cause),
    .enable_set (enable_set),
    .kick       (kick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (enabled),
    .load      (enable_set | kick),
    .reload    (reload),
    .cnt_q     (cnt),
    .expire    (expire),
    .rst_req_q (wdt_rst_req)
  );

  assign pready = 1'b1;
endmodule

// File: rtl/wdt_ctrl_chk.sv
module wdt_ctrl_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             kick,
  input logic             enable_set,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic [1:0]       cause,
  input logic             rst_req
);
  // R1
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (cnt == '0) && !rst_req);

  // R3
  enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable_set |=> en && (cnt == $past(reload)));

  // R4
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);

  // R5
  reload_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(reload));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !kick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1) && !rst_req);

  // R8
  expiry_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !kick && cnt == '0) |=> rst_req && (cnt == $past(reload)));

  // R8
  expiry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cause == 2'b11);
endmodule

bind wdt_ctrl wdt_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .en         (enabled),
  .kick       (kick),
  .enable_set (enable_set),
  .cnt        (cnt),
  .reload     (reload),
  .cause      (cause),
  .rst_req    (wdt_rst_req)
);

// File: tb/tb_wdt_ctrl.sv
module tb_wdt_ctrl;
  localparam int unsigned RLD = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        wdt_rst_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;
  int pulse_cyc[2];
  bit done = 1'b0;

  wdt_ctrl dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .pready(pready), .wdt_rst_req(wdt_rst_req)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && wdt_rst_req) begin
      if (pulses < 2) pulse_cyc[pulses] = cyc;
      pulses = pulses + 1;
    end
  end

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{1'b0, 12'h000, 32'h0,         32'h0000_8000, 4'd1},  // R1 reload default
    '{1'b0, 12'h004, 32'h0,         32'h0000_0000, 4'd1},  // R1 ctrl idle
    '{1'b0, 12'h008, 32'h0,         32'h0000_0001, 4'd1},  // R1 cause pin code
    '{1'b1, 12'h000, 32'h1234_5678, 32'h0,         4'd2},
    '{1'b0, 12'h000, 32'h0,         32'h1234_5678, 4'd2},  // R2 readback
    '{1'b1, 12'h004, 32'h0000_6699, 32'h0,         4'd7},
    '{1'b0, 12'h004, 32'h0,         32'h0000_0000, 4'd7},  // R7 key ignored when disabled
    '{1'b1, 12'h008, 32'h0000_0002, 32'h0,         4'd9},
    '{1'b0, 12'h008, 32'h0,         32'h0000_0002, 4'd9},  // R9 cause writable
    '{1'b1, 12'h008, 32'h0000_0001, 32'h0,         4'd9},
    '{1'b0, 12'h010, 32'h0,         32'h0000_0000, 4'd10}, // R10 unmapped
    '{1'b1, 12'h000, RLD,           32'h0,         4'd2},
    '{1'b0, 12'h000, 32'h0,         RLD,           4'd2}   // R2 second value
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d, output int ccyc);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    ccyc = cyc;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [31:0] d, output int scyc);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata;
    scyc = cyc;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: bench timed out, got 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int c, s, k, dummy;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1 rst_req idle", {31'b0, wdt_rst_req}, 32'h0);
    check("R10 pready", {31'b0, pready}, 32'h1);

    for (int i = 0; i < 13; i++) begin
      if (VEC[i].wr) apb_write(VEC[i].addr, VEC[i].data, dummy);
      else begin
        apb_read(VEC[i].addr, rd, dummy);
        check($sformatf("R%0d vector %0d", VEC[i].req, i), rd, VEC[i].exp);
      end
    end
    check("R1 no pulse while disabled", pulses, 0);

    // R3 enable loads counter; R6 one step per clock
    apb_write(12'h004, 32'h8000_0000, c);
    apb_read(12'h004, rd, s);
    check("R3 enable and load", rd, 32'h8000_0000 | (RLD - (s - c)));
    apb_read(12'h004, rd, s);
    check("R6 decrement", rd, 32'h8000_0000 | (RLD - (s - c)));

    // R5 reload locked
    apb_write(12'h000, 32'h0000_0099, dummy);
    apb_read(12'h000, rd, s);
    check("R5 reload locked", rd, RLD);

    // R4 disable attempt has no effect
    apb_write(12'h004, 32'h0000_0000, dummy);
    apb_read(12'h004, rd, s);
    check("R4 still enabled", rd, 32'h8000_0000 | (RLD - (s - c)));

    // R7 non-key value does not reload
    apb_write(12'h004, 32'h0000_1234, dummy);
    apb_read(12'h004, rd, s);
    check("R7 non-key ignored", rd, 32'h8000_0000 | (RLD - (s - c)));

    // R7 key reloads
    apb_write(12'h004, 32'h0000_6699, k);
    apb_read(12'h004, rd, s);
    check("R7 kick reloads", rd, 32'h8000_0000 | (RLD - (s - k)));
    check("R8 no early pulse", pulses, 0);

    // R8 free-running expiry
    while (pulses < 2) @(negedge clk);
    check("R8 first expiry cycle", pulse_cyc[0], k + RLD + 1);
    check("R8 second expiry cycle", pulse_cyc[1], k + 2 * (RLD + 1));
    apb_read(12'h004, rd, s);
    check("R8 reload after expiry", rd, 32'h8000_0000 | (RLD - (s - pulse_cyc[1])));
    check("R8 single-cycle pulses", pulses, 2);
    apb_read(12'h008, rd, s);
    check("R8 cause code", rd, 32'h0000_0003);

    // R9 software can overwrite cause
    apb_write(12'h008, 32'h0000_0000, dummy);
    apb_read(12'h008, rd, s);
    check("R9 cause cleared", rd, 32'h0);

    // R1 reset returns everything
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    apb_read(12'h004, rd, s);
    check("R1 ctrl after reset", rd, 32'h0);
    apb_read(12'h000, rd, s);
    check("R1 reload after reset", rd, 32'h0000_8000);
    apb_read(12'h008, rd, s);
    check("R1 cause after reset", rd, 32'h0000_0001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule